// File: doc/BRIEF.md
# Disk Sector Write Word Sequencer

This block supplies the word stream for one floppy sector once the sector header has been located. A start pulse chooses the operation. For a write, every strobe from the downstream serializer opens one word slot. The first slots carry data words taken from a host input buffer. The next slot carries a CRC-16 computed over those data words, the slot after it carries a zero post-amble word, and the last slot ends the sector. While a data word is being consumed, the block pulses a release strobe so the host can clear its buffer-full flag and load the next word. Once the host reports that the transfer is complete, the remaining data slots are filled with zeros.

For a read, the block counts a shorter frame of slots and never raises write-enable. This lets the surrounding controller use the same slot counter for both operations. Bit encoding and clock recovery happen downstream and are not part of this block.

Top module: `sector_wr_seq`

## Requirements
- R1: After reset, `wr_word` is 0, `wr_en` is 0, and `buf_release` and `sector_done` are 0. Strobes have no effect until a start pulse arrives.
- R2: A `start` pulse with `op_write`=1 presets the CRC to 0xFFFF and loads a 130-slot write frame. All outputs change only at the rising edge that samples `word_stb`=1, and the outputs then hold until the next such edge.
- R3: In a write frame, slots 1 to 127 are data slots. In each one, `wr_word` becomes `host_word`, or 0 if `xfer_done` is 1 at that edge, and `wr_en` is 1.
- R4: `buf_release` is a one-cycle pulse after data slots 1 to 126 in which `host_valid`=1 and `xfer_done`=0. It is never raised after slot 127, the CRC slot, the post-amble slot, or a read slot.
- R5: Slot 128 emits the CRC of data slots 1 to 127. The CRC uses polynomial 0x1021 with preset 0xFFFF, feeds each 16-bit word MSB first, has no final inversion, and includes the zero-filled words.
- R6: Slot 129 emits the word 0 with `wr_en` still 1.
- R7: Slot 130 drives `sector_done` high for one cycle and drives `wr_en` and `wr_word` to 0 at the same edge. After that the block is idle, and further strobes change nothing.
- R8: A `start` pulse with `op_write`=0 loads a 129-slot read frame. In this frame `wr_en` stays 0, `wr_word` stays 0, and `buf_release` stays 0. Slot 129 raises `sector_done`.
- R9: A `start` pulse in the middle of a frame abandons that frame. It clears `wr_en` and `wr_word`, then begins a fresh frame with a freshly preset CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sector frame |
| op_write | input | 1 | 1 = write frame, 0 = read frame, sampled with start |
| host_word | input | 16 | Word from host input buffer |
| host_valid | input | 1 | Host buffer holds a word |
| xfer_done | input | 1 | Host has no more data; fill with zeros |
| word_stb | input | 1 | Serializer requests the next word slot |
| wr_word | output | 16 | Word to serialize |
| wr_en | output | 1 | Write gate |
| buf_release | output | 1 | Pulse: host word consumed |
| sector_done | output | 1 | Pulse: frame finished |

## Verification
A slot counter that is off by one moves the CRC word to the wrong slot and shifts the `sector_done` pulse, so the error appears at the ports on the 127th to 130th strobe of the frame. A corrupted CRC register shows up only once, as the wrong word in slot 128. This is why every slot of full frames is compared, including the zero-filled ones. A stuck mode bit appears at the first strobe, as `wr_en` rising in a read frame or staying low in a write frame. A release computed against the wrong threshold appears as one extra or one missing pulse near the end of the data slots.

// File: rtl/sector_wr_seq.sv
module sector_wr_seq #(
  parameter int W           = 16,
  parameter int FRAME_WRITE = 130,
  parameter int FRAME_READ  = 129,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] SEED = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_write,
  input  logic [W-1:0] host_word,
  input  logic         host_valid,
  input  logic         xfer_done,
  input  logic         word_stb,
  output logic [W-1:0] wr_word,
  output logic         wr_en,
  output logic         buf_release,
  output logic         sector_done
);
  localparam int CW = $clog2(FRAME_WRITE + 1);
  localparam logic [CW-1:0] LOAD_WR = CW'(FRAME_WRITE);
  localparam logic [CW-1:0] LOAD_RD = CW'(FRAME_READ);
  localparam logic [CW-1:0] K_CRC   = CW'(2);
  localparam logic [CW-1:0] K_LAST  = CW'(3);

  function automatic logic [W-1:0] crc_step(input logic [W-1:0] c, input logic [W-1:0] d);
    logic [W-1:0] r;
    r = c;
    for (int i = W - 1; i >= 0; i--) begin
      if (r[W-1] ^ d[i]) r = (r << 1) ^ POLY;
      else               r = r << 1;
    end
    return r;
  endfunction

  logic          busy, wmode;
  logic [CW-1:0] cnt;
  logic [W-1:0]  crc;

  wire [CW-1:0] nxt    = cnt - 1'b1;
  wire [W-1:0]  data_w = xfer_done ? '0 : host_word;
  wire          slot   = busy && word_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      wmode       <= 1'b0;
      cnt         <= '0;
      crc         <= SEED;
      wr_word     <= '0;
      wr_en       <= 1'b0;
      buf_release <= 1'b0;
      sector_done <= 1'b0;
    end else begin
      buf_release <= 1'b0;
      sector_done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        wmode   <= op_write;
        cnt     <= op_write ? LOAD_WR : LOAD_RD;
        crc     <= SEED;
        wr_en   <= 1'b0;
        wr_word <= '0;
      end else if (slot) begin
        cnt <= nxt;
        if (nxt == '0) begin
          busy        <= 1'b0;
          wr_en       <= 1'b0;
          wr_word     <= '0;
          sector_done <= 1'b1;
        end else if (wmode) begin
          wr_en <= 1'b1;
          if (nxt > K_CRC) begin
            wr_word     <= data_w;
            crc         <= crc_step(crc, data_w);
            buf_release <= (nxt > K_LAST) && !xfer_done && host_valid;
          end else if (nxt == K_CRC) begin
            wr_word <= crc;
          end else begin
            wr_word <= '0;
          end
        end
      end
    end
  end
endmodule

module sector_wr_seq_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         word_stb,
  input logic [W-1:0] wr_word,
  input logic         wr_en,
  input logic         buf_release,
  input logic         sector_done
);
  a_r7_done_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
    sector_done |-> !wr_en);
  a_r7_done_follows_stb: assert property (@(posedge clk) disable iff (!rst_n)
    sector_done |-> $past(word_stb));
  a_r4_release_follows_stb: assert property (@(posedge clk) disable iff (!rst_n)
    buf_release |-> $past(word_stb) && wr_en);
  a_r4_release_excl_done: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_release, sector_done}));
  a_r2_hold_between_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(word_stb) && !$past(start)) |-> ($stable(wr_word) && $stable(wr_en)));
  a_r9_start_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !wr_en && wr_word == '0);
endmodule

bind sector_wr_seq sector_wr_seq_chk #(.W(W)) u_chk (.*);

// File: tb/test_sector_wr_seq.sv
module test_sector_wr_seq;
  logic clk = 0, rst_n = 0, start = 0, op_write = 0, host_valid = 0, xfer_done = 0, word_stb = 0;
  logic [15:0] host_word = '0;
  logic [15:0] wr_word;
  logic wr_en, buf_release, sector_done;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sector_wr_seq i_sector_wr_seq (.*);

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int b = 15; b >= 0; b--) begin
      logic fb = r[15] ^ d[b];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [15:0] pat(input int k, input int seed);
    return 16'((k * 16'h3B1 + seed * 16'h1357) ^ 16'hC0DE);
  endfunction

  task automatic do_start(input bit wr);
    @(negedge clk); start = 1; op_write = wr;
    @(negedge clk); start = 0;
  endtask

  task automatic strobe(input logic [15:0] w, input bit v, input bit xd);
    @(negedge clk); host_word = w; host_valid = v; xfer_done = xd; word_stb = 1;
    @(posedge clk); #1;
    @(negedge clk); word_stb = 0;
  endtask

  task automatic run_write(input int zero_after, input bit v, input int seed);
    logic [15:0] crc = 16'hFFFF;
    for (int k = 1; k <= 130; k++) begin
      bit xd = (k > zero_after);
      logic [15:0] w = pat(k, seed);
      logic [15:0] ew;
      @(negedge clk); host_word = w; host_valid = v; xfer_done = xd; word_stb = 1;
      @(posedge clk); #1;
      if (k <= 127) begin
        ew = xd ? 16'h0 : w;
        crc = ref_crc(crc, ew);
        chk("R3", "data word", wr_word, ew);
        chk("R3", "wr_en data", {15'b0, wr_en}, 16'd1);
        chk("R4", "release", {15'b0, buf_release}, {15'b0, (k <= 126) && v && !xd});
      end else if (k == 128) begin
        chk("R5", "crc word", wr_word, crc);
        chk("R4", "no release crc", {15'b0, buf_release}, 16'd0);
      end else if (k == 129) begin
        chk("R6", "postamble", wr_word, 16'h0);
        chk("R6", "wr_en postamble", {15'b0, wr_en}, 16'd1);
      end else begin
        chk("R7", "done", {15'b0, sector_done}, 16'd1);
        chk("R7", "wr_en off", {15'b0, wr_en}, 16'd0);
        chk("R7", "word off", wr_word, 16'h0);
      end
      if (k < 130) chk("R7", "no early done", {15'b0, sector_done}, 16'd0);
      @(negedge clk); word_stb = 0;
    end
    @(posedge clk); #1;
    chk("R7", "done one cycle", {15'b0, sector_done}, 16'd0);
  endtask

  task automatic t_reset;
    chk("R1", "wr_word", wr_word, 16'h0);
    chk("R1", "wr_en", {15'b0, wr_en}, 16'd0);
    chk("R1", "release", {15'b0, buf_release}, 16'd0);
    chk("R1", "done", {15'b0, sector_done}, 16'd0);
    strobe(16'hFFFF, 1, 0);
    chk("R1", "idle strobe word", wr_word, 16'h0);
    chk("R1", "idle strobe en", {15'b0, wr_en}, 16'd0);
  endtask

  task automatic t_write_full;
    do_start(1); run_write(200, 1, 1);
  endtask

  task automatic t_write_zero_fill;
    do_start(1); run_write(10, 1, 2);
  endtask

  task automatic t_write_no_valid;
    do_start(1); run_write(200, 0, 3);
  endtask

  task automatic t_hold_and_idle;
    do_start(1);
    strobe(16'h1234, 1, 0);
    repeat (3) @(posedge clk); #1;
    chk("R2", "hold word", wr_word, 16'h1234);
    chk("R4", "release one cycle", {15'b0, buf_release}, 16'd0);
    do_start(1);
    chk("R9", "restart clears en", {15'b0, wr_en}, 16'd0);
    run_write(200, 1, 4);
    strobe(16'hBEEF, 1, 0);
    chk("R7", "idle after done", wr_word, 16'h0);
    chk("R7", "idle no done", {15'b0, sector_done}, 16'd0);
  endtask

  task automatic t_read;
    do_start(0);
    for (int k = 1; k <= 129; k++) begin
      @(negedge clk); host_word = pat(k, 5); host_valid = 1; xfer_done = 0; word_stb = 1;
      @(posedge clk); #1;
      chk("R8", "read wr_en", {15'b0, wr_en}, 16'd0);
      chk("R8", "read word", wr_word, 16'h0);
      chk("R8", "read release", {15'b0, buf_release}, 16'd0);
      chk("R8", "read done", {15'b0, sector_done}, {15'b0, k == 129});
      @(negedge clk); word_stb = 0;
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1;
    t_reset();
    t_write_full();
    t_write_zero_fill();
    t_write_no_valid();
    t_read();
    t_hold_and_idle();
    finish_run();
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule